// File: doc/BRIEF.md
# Interrupt Steering Register Bank

This block is a memory-mapped register bank that routes device interrupt lines to target processors and turns software writes into inter-processor interrupt requests. Each interrupt source has two 8-byte-spaced registers: a steering entry that names the target CPU and the vector, and a control entry that holds a mask flag and a pending flag. A rising edge on a device line sets that source's pending flag. When the source is not masked, the edge also produces a one-cycle interrupt request that carries the stored CPU and vector.

Software uses a simple 64-bit bus to reach the bank. The bus has a request strobe, a write enable, a 12-bit byte offset and write data. Every request is answered one cycle later with an acknowledge, read data and an error flag. Pending is read at bit 0 of the control entry, but software clears it by writing a 1 to bit 1, so restoring the mask cannot clear pending by accident. A write-only dispatch window turns a single bus write into an inter-processor interrupt request. A separate register stores one 6-bit vector.

Top module: `irq_steer_bank`

## Requirements
- R1: Every cycle with bus_req high is answered by bus_ack high in the next cycle. bus_ack is low after a cycle without a request. bus_rdata and bus_err are valid together with bus_ack.
- R2: The steering entry of source i sits at offset 0x000 + 8*i, and offset bits 2:0 are ignored. A write stores the CPU from data bits 12:8 and the vector from bits 5:0. A read returns the entry in the same bit positions, with all other bits zero.
- R3: The control entry of source i sits at offset 0x100 + 8*i. A read returns the mask in bit 2 and pending in bit 0, with all other bits zero. A write loads the mask from bit 2. Mask = 1 means the source is blocked.
- R4: A write to a control entry clears pending only when data bit 1 is 1. When bit 1 is 0, pending is left unchanged.
- R5: A rising edge on dev_irq[i] sets pending of source i at the next clock edge. A line held high does not set pending again after software has cleared it.
- R6: A rising edge on an unmasked source gives an irq_valid pulse one cycle wide, two clock edges after the edge is sampled. The pulse carries irq_src = i and the source's stored CPU and vector.
- R7: A rising edge on a masked source sets pending but produces no irq_valid pulse.
- R8: If a rising edge and a software clear of pending hit the same source in the same cycle, pending ends up 1.
- R9: When several unmasked sources rise in the same cycle, their requests leave one per cycle, lowest source index first.
- R10: The single vector register at offset 0x200 takes data bits 5:0 on a write. It reads back zero-extended.
- R11: A write to the dispatch window (offsets 0x300 to 0x31F) raises ipi_valid for exactly the next cycle. The request carries ipi_type from data bits 17:16, ipi_cpu from bits 12:8 and ipi_vec from bits 5:0. A read of this window is an error.
- R12: An access to any offset outside the defined regions returns bus_err with bus_ack and zero read data, and it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset into the bank |
| bus_wdata | input | 64 | Write data |
| bus_ack | output | 1 | Response strobe, one cycle after bus_req |
| bus_err | output | 1 | Access hit no valid target |
| bus_rdata | output | 64 | Read data, valid with bus_ack |
| dev_irq | input | NUM_SRC | Device interrupt lines, edge-detected |
| irq_valid | output | 1 | Device interrupt request pulse |
| irq_src | output | clog2(NUM_SRC) | Source of the request |
| irq_cpu | output | 5 | Target CPU of the request |
| irq_vec | output | 6 | Vector of the request |
| ipi_valid | output | 1 | Inter-processor interrupt pulse |
| ipi_type | output | 2 | IPI type |
| ipi_cpu | output | 5 | IPI target CPU |
| ipi_vec | output | 6 | IPI vector |

## Verification
The hardest case to reach is a device edge and a software clear of pending that land on the same source in the same clock cycle. A plain bus task cannot do this, because it hides the cycle in which the write is sampled. The bench therefore drives the interrupt line and the bus write at the same falling edge, with the source already pending, and then reads the control entry back. It also raises two unmasked lines together to show the ordering, and it clears pending while a line is still held high to show that a level does not re-trigger. Random writes with random low offset bits check the steering and control layouts against a shadow model in the bench.

// File: rtl/irq_steer_pkg.sv
`timescale 1ns/1ps
package irq_steer_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 64;
    localparam int CPU_W    = 5;
    localparam int VEC_W    = 6;
    localparam int TYPE_W   = 2;

    // field positions in the 64-bit word
    localparam int CPU_LSB  = 8;
    localparam int VEC_LSB  = 0;
    localparam int TYPE_LSB = 16;
    localparam int MASK_BIT = 2;
    localparam int CLR_BIT  = 1;
    localparam int PEND_BIT = 0;

    // region bases
    localparam logic [ADDR_W-1:0] STEER_BASE = 12'h000;
    localparam logic [ADDR_W-1:0] CTRL_BASE  = 12'h100;
    localparam logic [ADDR_W-1:0] VREG_ADDR  = 12'h200;
    localparam logic [ADDR_W-1:0] DISP_BASE  = 12'h300;
    localparam int                SLOT_SHIFT = 3;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_STEER,
        RG_CTRL,
        RG_VREG,
        RG_DISP
    } region_e;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } steer_t;

    typedef struct packed {
        logic mask;
        logic pend;
    } ctrl_t;

    typedef struct packed {
        logic [TYPE_W-1:0] kind;
        logic [CPU_W-1:0]  cpu;
        logic [VEC_W-1:0]  vec;
    } ipi_t;

    function automatic steer_t steer_from_word(input logic [DATA_W-1:0] w);
        steer_t s;
        s.cpu = w[CPU_LSB +: CPU_W];
        s.vec = w[VEC_LSB +: VEC_W];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] steer_to_word(input steer_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CPU_LSB +: CPU_W] = s.cpu;
        w[VEC_LSB +: VEC_W] = s.vec;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MASK_BIT] = c.mask;
        w[PEND_BIT] = c.pend;
        return w;
    endfunction

    function automatic ipi_t ipi_from_word(input logic [DATA_W-1:0] w);
        ipi_t p;
        p.kind = w[TYPE_LSB +: TYPE_W];
        p.cpu  = w[CPU_LSB +: CPU_W];
        p.vec  = w[VEC_LSB +: VEC_W];
        return p;
    endfunction

endpackage

// File: rtl/irq_steer_decode.sv
`timescale 1ns/1ps
module irq_steer_decode
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC    = 16,
    parameter int DISP_SLOTS = 4,
    parameter int IDX_W      = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] SRC_SPAN  = ADDR_W'(NUM_SRC << SLOT_SHIFT);
    localparam logic [ADDR_W-1:0] DISP_SPAN = ADDR_W'(DISP_SLOTS << SLOT_SHIFT);

    logic [ADDR_W-1:0] rel_steer;
    logic [ADDR_W-1:0] rel_ctrl;
    logic [ADDR_W-1:0] rel_disp;

    always_comb begin
        rel_steer = addr - STEER_BASE;
        rel_ctrl  = addr - CTRL_BASE;
        rel_disp  = addr - DISP_BASE;
        region    = RG_NONE;
        idx       = '0;
        if (rel_steer < SRC_SPAN) begin
            region = RG_STEER;
            idx    = rel_steer[SLOT_SHIFT +: IDX_W];
        end else if (rel_ctrl < SRC_SPAN) begin
            region = RG_CTRL;
            idx    = rel_ctrl[SLOT_SHIFT +: IDX_W];
        end else if (addr == VREG_ADDR) begin
            region = RG_VREG;
        end else if (rel_disp < DISP_SPAN) begin
            region = RG_DISP;
        end
    end

endmodule

// File: rtl/irq_steer_src.sv
`timescale 1ns/1ps
module irq_steer_src
    import irq_steer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_steer,
    input  steer_t steer_wr,
    input  logic   wr_ctrl,
    input  logic   mask_wr,
    input  logic   clr_wr,
    input  logic   dev_in,
    input  logic   grant,
    output steer_t steer_q,
    output ctrl_t  ctrl_q,
    output logic   owed_q
);
    logic dev_prev;
    logic rise;
    logic sw_clear;

    assign rise     = dev_in & ~dev_prev;
    assign sw_clear = wr_ctrl & clr_wr & ~rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_prev <= 1'b0;
            steer_q  <= '0;
            ctrl_q   <= '0;
            owed_q   <= 1'b0;
        end else begin
            dev_prev <= dev_in;
            if (wr_steer)
                steer_q <= steer_wr;
            if (wr_ctrl)
                ctrl_q.mask <= mask_wr;
            // a device edge beats a software clear in the same cycle
            if (rise)
                ctrl_q.pend <= 1'b1;
            else if (sw_clear)
                ctrl_q.pend <= 1'b0;
            if (rise && !ctrl_q.mask)
                owed_q <= 1'b1;
            else if (grant || sw_clear)
                owed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_steer_arb.sv
`timescale 1ns/1ps
module irq_steer_arb #(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] grant,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        // scan downward so the lowest requesting index is the last one taken
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                any   = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_steer_bank.sv
`timescale 1ns/1ps
module irq_steer_bank
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC    = 16,
    parameter int DISP_SLOTS = 4,
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ack,
    output logic                 bus_err,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   dev_irq,
    output logic                 irq_valid,
    output logic [IDX_W-1:0]     irq_src,
    output logic [CPU_W-1:0]     irq_cpu,
    output logic [VEC_W-1:0]     irq_vec,
    output logic                 ipi_valid,
    output logic [TYPE_W-1:0]    ipi_type,
    output logic [CPU_W-1:0]     ipi_cpu,
    output logic [VEC_W-1:0]     ipi_vec
);
    region_e            region;
    logic [IDX_W-1:0]   idx;
    logic               wr;
    logic               rd;
    steer_t             steer_wr;
    ipi_t               ipi_wr;
    logic               access_bad;
    logic [DATA_W-1:0]  rd_word;

    steer_t             steer_arr [NUM_SRC];
    ctrl_t              ctrl_arr  [NUM_SRC];
    logic [NUM_SRC-1:0] owed_vec;
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] grant_vec;
    logic               grant_any;
    logic [IDX_W-1:0]   grant_idx;
    logic [VEC_W-1:0]   vreg_q;

    wire unused_wdata = ^{bus_wdata[DATA_W-1:TYPE_LSB+TYPE_W],
                          bus_wdata[TYPE_LSB-1:CPU_LSB+CPU_W],
                          bus_wdata[CPU_LSB-1:MASK_BIT+1]};

    irq_steer_decode #(
        .NUM_SRC    (NUM_SRC),
        .DISP_SLOTS (DISP_SLOTS),
        .IDX_W      (IDX_W)
    ) decode_i (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    assign wr       = bus_req & bus_we;
    assign rd       = bus_req & ~bus_we;
    assign steer_wr = steer_from_word(bus_wdata);
    assign ipi_wr   = ipi_from_word(bus_wdata);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            logic hit;
            assign hit = (idx == IDX_W'(g));
            irq_steer_src src_i (
                .clk      (clk),
                .rst      (rst),
                .wr_steer (wr && region == RG_STEER && hit),
                .steer_wr (steer_wr),
                .wr_ctrl  (wr && region == RG_CTRL && hit),
                .mask_wr  (bus_wdata[MASK_BIT]),
                .clr_wr   (bus_wdata[CLR_BIT]),
                .dev_in   (dev_irq[g]),
                .grant    (grant_vec[g]),
                .steer_q  (steer_arr[g]),
                .ctrl_q   (ctrl_arr[g]),
                .owed_q   (owed_vec[g])
            );
            assign mask_vec[g] = ctrl_arr[g].mask;
        end
    endgenerate

    irq_steer_arb #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) arb_i (
        .req   (owed_vec & ~mask_vec),
        .grant (grant_vec),
        .any   (grant_any),
        .idx   (grant_idx)
    );

    always_comb begin
        access_bad = (region == RG_NONE) || (region == RG_DISP && !bus_we);
        unique case (region)
            RG_STEER: rd_word = steer_to_word(steer_arr[idx]);
            RG_CTRL:  rd_word = ctrl_to_word(ctrl_arr[idx]);
            RG_VREG:  rd_word = DATA_W'(vreg_q);
            default:  rd_word = '0;
        endcase
    end

    // bus response
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_req;
            bus_err   <= bus_req && access_bad;
            bus_rdata <= (rd && !access_bad) ? rd_word : '0;
        end
    end

    // single vector register
    always_ff @(posedge clk) begin
        if (rst)
            vreg_q <= '0;
        else if (wr && region == RG_VREG)
            vreg_q <= bus_wdata[VEC_LSB +: VEC_W];
    end

    // inter-processor interrupt dispatch
    always_ff @(posedge clk) begin
        if (rst) begin
            ipi_valid <= 1'b0;
            ipi_type  <= '0;
            ipi_cpu   <= '0;
            ipi_vec   <= '0;
        end else begin
            ipi_valid <= wr && region == RG_DISP;
            if (wr && region == RG_DISP) begin
                ipi_type <= ipi_wr.kind;
                ipi_cpu  <= ipi_wr.cpu;
                ipi_vec  <= ipi_wr.vec;
            end
        end
    end

    // device interrupt request output
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_src   <= '0;
            irq_cpu   <= '0;
            irq_vec   <= '0;
        end else begin
            irq_valid <= grant_any;
            if (grant_any) begin
                irq_src <= grant_idx;
                irq_cpu <= steer_arr[grant_idx].cpu;
                irq_vec <= steer_arr[grant_idx].vec;
            end
        end
    end

endmodule

// File: rtl/irq_steer_bank_chk.sv
`timescale 1ns/1ps
module irq_steer_bank_chk
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_req,
    input logic               bus_we,
    input logic               bus_ack,
    input logic               bus_err,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_valid,
    input logic [IDX_W-1:0]   irq_src,
    input logic               ipi_valid,
    input logic [NUM_SRC-1:0] mask_vec
);
    logic [NUM_SRC-1:0] mask_d;

    always_ff @(posedge clk) begin
        if (rst) mask_d <= '0;
        else     mask_d <= mask_vec;
    end

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ack); // R1
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_ack); // R1
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_ack && bus_rdata == '0)); // R12
    AST_IPI_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        ipi_valid |-> $past(bus_req && bus_we)); // R11
    AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !mask_d[irq_src]); // R7

endmodule

bind irq_steer_bank irq_steer_bank_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .irq_valid (irq_valid),
    .irq_src   (irq_src),
    .ipi_valid (ipi_valid),
    .mask_vec  (mask_vec)
);

// File: tb/irq_steer_bank_tb.sv
`timescale 1ns/1ps
module irq_steer_bank_tb_top;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [63:0] bus_rdata;
    logic [NS-1:0] dev_irq = '0;
    logic        irq_valid;
    logic [3:0]  irq_src;
    logic [4:0]  irq_cpu;
    logic [5:0]  irq_vec;
    logic        ipi_valid;
    logic [1:0]  ipi_type;
    logic [4:0]  ipi_cpu;
    logic [5:0]  ipi_vec;

    int compared = 0;
    int mismatched = 0;
    int irq_cnt = 0;

    logic        r_ack, r_err;
    logic [63:0] r_data;

    logic [4:0] sh_cpu  [NS];
    logic [5:0] sh_vec  [NS];
    logic       sh_mask [NS];
    logic       sh_pend [NS];

    irq_steer_bank #(.NUM_SRC(NS), .DISP_SLOTS(4)) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .dev_irq(dev_irq),
        .irq_valid(irq_valid), .irq_src(irq_src), .irq_cpu(irq_cpu),
        .irq_vec(irq_vec), .ipi_valid(ipi_valid), .ipi_type(ipi_type),
        .ipi_cpu(ipi_cpu), .ipi_vec(ipi_vec)
    );

    always #2 clk = ~clk;

    always @(negedge clk) if (irq_valid) irq_cnt++;

    function automatic logic [63:0] exp_steer(input int i);
        return (64'(sh_cpu[i]) << 8) | 64'(sh_vec[i]);
    endfunction

    function automatic logic [63:0] exp_ctrl(input int i);
        return (64'(sh_mask[i]) << 2) | 64'(sh_pend[i]);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic we, input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        r_ack = bus_ack; r_err = bus_err; r_data = bus_rdata;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NS; i++) begin
            sh_cpu[i] = '0; sh_vec[i] = '0; sh_mask[i] = 1'b0; sh_pend[i] = 1'b0;
        end
        cycles(3);
        rst = 1'b0;
        #1;
        check("R1 reset ack", 64'(bus_ack), 0);
        check("R6 reset irq_valid", 64'(irq_valid), 0);
        check("R11 reset ipi_valid", 64'(ipi_valid), 0);
        bus_xfer(1'b0, 12'h018, '0);
        check("R2 reset steer", r_data, 0);
        bus_xfer(1'b0, 12'h118, '0);
        check("R3 reset ctrl", r_data, 0);

        // random writes to steering and control entries
        for (int n = 0; n < 60; n++) begin
            int s;
            logic [63:0] d;
            logic [11:0] lo;
            s  = int'($urandom % NS);
            d  = {$urandom, $urandom};
            lo = 12'($urandom % 8);
            if ($urandom % 2 == 0) begin
                bus_xfer(1'b1, 12'(8 * s) + lo, d);
                sh_cpu[s] = d[12:8]; sh_vec[s] = d[5:0];
            end else begin
                bus_xfer(1'b1, 12'h100 + 12'(8 * s) + lo, d);
                sh_mask[s] = d[2];
                if (d[1]) sh_pend[s] = 1'b0;
            end
            check("R1 write ack", 64'(r_ack), 1);
        end
        for (int i = 0; i < NS; i++) begin
            bus_xfer(1'b0, 12'(8 * i), '0);
            check("R2 steer readback", r_data, exp_steer(i));
            bus_xfer(1'b0, 12'h100 + 12'(8 * i), '0);
            check("R3 ctrl readback", r_data, exp_ctrl(i));
            check("R1 read err", 64'(r_err), 0);
        end

        // R6: unmasked edge produces a request with stored routing
        bus_xfer(1'b1, 12'h148, 64'h0);
        sh_mask[9] = 1'b0;
        bus_xfer(1'b1, 12'h048, 64'h1E33);
        sh_cpu[9] = 5'h1E; sh_vec[9] = 6'h33;
        c0 = irq_cnt;
        @(negedge clk); dev_irq[9] = 1'b1;
        cycles(1);
        check("R6 not yet", 64'(irq_valid), 0);
        cycles(1);
        check("R6 irq_valid", 64'(irq_valid), 1);
        check("R6 irq_src", 64'(irq_src), 9);
        check("R6 irq_cpu", 64'(irq_cpu), 64'h1E);
        check("R6 irq_vec", 64'(irq_vec), 64'h33);
        cycles(1);
        check("R6 one cycle", 64'(irq_valid), 0);
        bus_xfer(1'b0, 12'h148, '0);
        check("R5 pending set", r_data, 64'h1);
        // R5: clear while the line stays high, no re-trigger
        bus_xfer(1'b1, 12'h148, 64'h2);
        cycles(4);
        bus_xfer(1'b0, 12'h148, '0);
        check("R5 held level no reset", r_data, 64'h0);
        check("R5 single request", 64'(irq_cnt - c0), 1);
        @(negedge clk); dev_irq[9] = 1'b0;

        // R7: masked source
        bus_xfer(1'b1, 12'h120, 64'h4);
        c0 = irq_cnt;
        @(negedge clk); dev_irq[4] = 1'b1;
        cycles(4);
        check("R7 no request", 64'(irq_cnt - c0), 0);
        bus_xfer(1'b0, 12'h120, '0);
        check("R7 pending set", r_data, 64'h5);
        @(negedge clk); dev_irq[4] = 1'b0;

        // R4: clear only with bit 1
        bus_xfer(1'b1, 12'h120, 64'h4);
        bus_xfer(1'b0, 12'h120, '0);
        check("R4 bit1 zero keeps", r_data, 64'h5);
        bus_xfer(1'b1, 12'h120, 64'h6);
        bus_xfer(1'b0, 12'h120, '0);
        check("R4 bit1 clears", r_data, 64'h4);

        // R8: edge and clear in the same cycle
        @(negedge clk); dev_irq[4] = 1'b1;
        cycles(2);
        @(negedge clk); dev_irq[4] = 1'b0;
        bus_xfer(1'b0, 12'h120, '0);
        check("R8 precondition", r_data, 64'h5);
        @(negedge clk);
        dev_irq[4] = 1'b1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h120; bus_wdata = 64'h6;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
        bus_xfer(1'b0, 12'h120, '0);
        check("R8 set wins", r_data, 64'h5);
        @(negedge clk); dev_irq[4] = 1'b0;

        // R9: two sources together, lowest first
        bus_xfer(1'b1, 12'h110, 64'h0);
        bus_xfer(1'b1, 12'h128, 64'h0);
        bus_xfer(1'b1, 12'h010, 64'h0211);
        bus_xfer(1'b1, 12'h028, 64'h0522);
        @(negedge clk); dev_irq[2] = 1'b1; dev_irq[5] = 1'b1;
        cycles(2);
        check("R9 first valid", 64'(irq_valid), 1);
        check("R9 first src", 64'(irq_src), 2);
        check("R9 first vec", 64'(irq_vec), 64'h11);
        cycles(1);
        check("R9 second valid", 64'(irq_valid), 1);
        check("R9 second src", 64'(irq_src), 5);
        check("R9 second cpu", 64'(irq_cpu), 64'h05);
        cycles(1);
        check("R9 done", 64'(irq_valid), 0);
        @(negedge clk); dev_irq[2] = 1'b0; dev_irq[5] = 1'b0;

        // R10: single vector register
        bus_xfer(1'b1, 12'h200, 64'hFFFF_FFFF_FFFF_FFC5);
        bus_xfer(1'b0, 12'h200, '0);
        check("R10 zero extended", r_data, 64'h05);

        // R11: dispatch
        bus_xfer(1'b1, 12'h308, 64'hABCD_0002_F3EA);
        check("R11 ipi_valid", 64'(ipi_valid), 1);
        check("R11 ipi_type", 64'(ipi_type), 2);
        check("R11 ipi_cpu", 64'(ipi_cpu), 64'h13);
        check("R11 ipi_vec", 64'(ipi_vec), 64'h2A);
        check("R11 write ok", 64'(r_err), 0);
        cycles(1);
        check("R11 one cycle", 64'(ipi_valid), 0);
        for (int n = 0; n < 8; n++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            bus_xfer(1'b1, 12'h300 + 12'($urandom % 32), d);
            check("R11 rand type", 64'(ipi_type), 64'(d[17:16]));
            check("R11 rand cpu/vec", {ipi_cpu, ipi_vec}, {d[12:8], d[5:0]});
        end
        bus_xfer(1'b0, 12'h300, '0);
        check("R11 read err", 64'(r_err), 1);

        // R12: unknown offsets
        bus_xfer(1'b1, 12'h080, '1);
        check("R12 write err", 64'(r_err), 1);
        check("R12 write ack", 64'(r_ack), 1);
        check("R12 no ipi", 64'(ipi_valid), 0);
        bus_xfer(1'b1, 12'h180, '1);
        bus_xfer(1'b0, 12'h208, '0);
        check("R12 read err", 64'(r_err), 1);
        check("R12 read data", r_data, 0);
        bus_xfer(1'b0, 12'h000, '0);
        check("R12 steer intact", r_data, exp_steer(0));
        bus_xfer(1'b0, 12'h100, '0);
        check("R12 ctrl intact", r_data, exp_ctrl(0));
        bus_xfer(1'b0, 12'h200, '0);
        check("R12 vreg intact", r_data, 64'h05);

        cycles(2);
        finish_run();
    end

endmodule